// File: doc/BRIEF.md
# Correction Counter Pulse Multiplier

The block holds a 16-bit correction count that advances on the peripheral clock towards a moving target supplied by a companion counter. Each time the count advances, the block raises a one-cycle count-up pulse. Downstream timer channels use that pulse as a clock enable, so the block acts as a frequency multiplier for a slower reference. The count stops at a programmable clear limit. Reaching that limit raises a one-cycle match strobe, and this strobe can clear any subset of up to four downstream counters through per-channel enables.

A correction sequence starts when a reference edge arrives while a separate interval counter reports zero. If the count already sits at or above the limit, the count reloads to 1 at once. If the count is below the limit, the block ignores the target and runs itself up to the limit, one step and one pulse per clock. It reloads to 1 on the clock after it arrives.

The target source, the interval counter and the downstream counters are outside this block.

Top module: `corr_mult_counter`

## Requirements
- R1: Synchronous active-low reset forces count_o to 0 and step_o, lim_hit_o and clr_o to 0. It also abandons any correction run in progress, so after release the count stays at 0 while target_i is 0.
- R2: Outside a correction run, when count_o is below target_i and not equal to limit_i, the next clock edge advances count_o by one, and step_o is 1 in the cycle that shows the new value.
- R3: Outside a correction run, when count_o is at or above target_i, count_o holds and step_o stays 0.
- R4: Outside a correction run, when count_o equals limit_i, count_o holds and step_o stays 0 even if target_i is larger.
- R5: lim_hit_o is a single-cycle pulse. It is 1 exactly in the cycle where count_o has just stepped to a value equal to limit_i. A reload never raises it.
- R6: clr_o[i] is 1 only in a lim_hit_o cycle and only when bit i of clr_en_i was 1 at the edge that produced the hit. With clr_en_i all 0, no clear is issued.
- R7: A correction sequence starts on a clock edge where ref_edge_i and ivl_zero_i are both 1. A reference edge while ivl_zero_i is 0 has no effect on count_o.
- R8: A correction sequence started while count_o is at or above limit_i reloads count_o to 1 on that edge, with step_o 0.
- R9: A correction sequence started while count_o is below limit_i steps count_o by one per clock with step_o 1, regardless of target_i, until it equals limit_i. The next edge reloads it to 1 with step_o 0, and target tracking then resumes.
- R10: Reference edges that arrive during a correction run neither restart nor lengthen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| target_i | input | CNT_W | Moving target from the companion counter |
| limit_i | input | CNT_W | Clear-limit value |
| ref_edge_i | input | 1 | One-cycle reference edge event |
| ivl_zero_i | input | 1 | Interval counter reads zero |
| clr_en_i | input | N_CLR | Per-channel enables for limit-match clears |
| step_o | output | 1 | Registered count-up pulse |
| count_o | output | CNT_W | Current correction count |
| lim_hit_o | output | 1 | Registered limit-match strobe |
| clr_o | output | N_CLR | Registered per-channel clear strobes |

## Verification
The count is visible on count_o directly, so a wrong increment, hold or reload shows as a count mismatch on the next clock edge. A bad step decision also shows in the same cycle as a step_o pulse that does not match the change in the count.

The hidden correction-run flag can only be seen through its effect. A run that is lost or left stuck shows as the count advancing past, or stalling below, a target smaller than itself within one clock. It also shows as a missing or extra reload right after the limit match.

The bench compares every output against a behavioural model on every clock. Any such fault is therefore reported in the cycle it first reaches a port.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD   = 2'd0,
      ACT_STEP   = 2'd1,
      ACT_RELOAD = 2'd2
   } corr_act_e;
endpackage

// File: rtl/corr_cmp.sv
`timescale 1ns/1ps
module corr_cmp #(
   parameter int W = 16
) (
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] tgt_i,
   input  logic [W-1:0] lim_i,
   output logic         below_tgt_o,
   output logic         at_lim_o,
   output logic         below_lim_o
);
   assign below_tgt_o = cnt_i < tgt_i;
   assign at_lim_o    = cnt_i == lim_i;
   assign below_lim_o = cnt_i < lim_i;
endmodule

// File: rtl/corr_seq.sv
`timescale 1ns/1ps
module corr_seq
   import corr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      below_tgt_i,
   input  logic      at_lim_i,
   input  logic      below_lim_i,
   output corr_act_e act_o,
   output logic      run_o
);
   logic run_q;
   logic run_eff;

   // a start in the current cycle behaves as an already running sequence
   assign run_eff = run_q | start_i;

   always_comb begin
      if (run_eff) begin
         act_o = below_lim_i ? ACT_STEP : ACT_RELOAD;
      end else if (below_tgt_i && !at_lim_i) begin
         act_o = ACT_STEP;
      end else begin
         act_o = ACT_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else begin
         run_q <= run_eff & below_lim_i;
      end
   end

   assign run_o = run_q;
endmodule

// File: rtl/corr_clr_fan.sv
`timescale 1ns/1ps
module corr_clr_fan #(
   parameter int N       = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] clr_o
);
   for (genvar g = 0; g < N; g++) begin : g_ch
      if (REG_OUT) begin : g_reg
         logic clr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               clr_q <= 1'b0;
            end else begin
               clr_q <= hit_i & en_i[g];
            end
         end
         assign clr_o[g] = clr_q;
      end else begin : g_comb
         assign clr_o[g] = hit_i & en_i[g];
      end
   end
endmodule

// File: rtl/corr_mult_counter.sv
`timescale 1ns/1ps
module corr_mult_counter
   import corr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int N_CLR      = 4,
   parameter int RELOAD_VAL = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] target_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             ref_edge_i,
   input  logic             ivl_zero_i,
   input  logic [N_CLR-1:0] clr_en_i,
   output logic             step_o,
   output logic [CNT_W-1:0] count_o,
   output logic             lim_hit_o,
   output logic [N_CLR-1:0] clr_o
);
   localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
   localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD_VAL);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("corr_mult_counter: CNT_W must lie in 2..32");
   end
   if (N_CLR < 1 || N_CLR > 16) begin : g_bad_nclr
      $error("corr_mult_counter: N_CLR must lie in 1..16");
   end
   if (RELOAD_VAL < 0) begin : g_bad_reload
      $error("corr_mult_counter: RELOAD_VAL must not be negative");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             step_q;
   logic             hit_q;
   logic             hit_d;
   logic             start;
   logic             below_tgt;
   logic             at_lim;
   logic             below_lim;
   logic             run_q;
   corr_act_e        act;

   assign start   = ref_edge_i & ivl_zero_i;
   assign cnt_inc = cnt_q + ONE_C;
   assign hit_d   = (act == ACT_STEP) && (cnt_inc == limit_i);

   corr_cmp #(.W(CNT_W)) u_cmp (
      .cnt_i       (cnt_q),
      .tgt_i       (target_i),
      .lim_i       (limit_i),
      .below_tgt_o (below_tgt),
      .at_lim_o    (at_lim),
      .below_lim_o (below_lim)
   );

   corr_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .below_tgt_i (below_tgt),
      .at_lim_i    (at_lim),
      .below_lim_i (below_lim),
      .act_o       (act),
      .run_o       (run_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         step_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         case (act)
            ACT_STEP:   cnt_q <= cnt_inc;
            ACT_RELOAD: cnt_q <= RELOAD_C;
            default:    cnt_q <= cnt_q;
         endcase
         step_q <= act == ACT_STEP;
         hit_q  <= hit_d;
      end
   end

   corr_clr_fan #(.N(N_CLR), .REG_OUT(1'b1)) u_fan (
      .clk   (clk),
      .rst_n (rst_n),
      .hit_i (hit_d),
      .en_i  (clr_en_i),
      .clr_o (clr_o)
   );

   assign count_o   = cnt_q;
   assign step_o    = step_q;
   assign lim_hit_o = hit_q;
endmodule

// File: rtl/corr_mult_counter_chk.sv
`timescale 1ns/1ps
module corr_mult_counter_chk #(
   parameter int CNT_W      = 16,
   parameter int N_CLR      = 4,
   parameter int RELOAD_VAL = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] target_i,
   input logic [CNT_W-1:0] limit_i,
   input logic             ref_edge_i,
   input logic             ivl_zero_i,
   input logic [N_CLR-1:0] clr_en_i,
   input logic             step_o,
   input logic [CNT_W-1:0] count_o,
   input logic             lim_hit_o,
   input logic [N_CLR-1:0] clr_o,
   input logic             run_q
);
   localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD_VAL);
   logic start;
   assign start = ref_edge_i & ivl_zero_i;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (count_o == '0 && !step_o && !lim_hit_o && clr_o == '0));

   // R2
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && $past(rst_n)) |-> count_o == $past(count_o) + CNT_W'(1));

   // R3
   tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !run_q && !start && count_o >= target_i) |-> !step_o);

   // R4
   lim_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !run_q && !start && count_o == limit_i) |-> !step_o);

   // R5
   hit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lim_hit_o |-> (step_o && count_o == $past(limit_i)));

   // R5
   hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lim_hit_o |=> !lim_hit_o);

   // R6
   clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_o != '0) |-> (lim_hit_o && clr_o == $past(clr_en_i)));

   // R8
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && (run_q || start) && count_o >= limit_i)
         |-> (count_o == RELOAD_C && !step_o));

   // R9
   run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && (run_q || start) && count_o < limit_i) |-> step_o);
endmodule

bind corr_mult_counter corr_mult_counter_chk #(
   .CNT_W      (CNT_W),
   .N_CLR      (N_CLR),
   .RELOAD_VAL (RELOAD_VAL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .target_i   (target_i),
   .limit_i    (limit_i),
   .ref_edge_i (ref_edge_i),
   .ivl_zero_i (ivl_zero_i),
   .clr_en_i   (clr_en_i),
   .step_o     (step_o),
   .count_o    (count_o),
   .lim_hit_o  (lim_hit_o),
   .clr_o      (clr_o),
   .run_q      (run_q)
);

// File: tb/corr_mult_counter_bench.sv
`timescale 1ns/1ps
module corr_mult_counter_bench;
   localparam int W = 16;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] target = '0;
   logic [W-1:0] limit = '0;
   logic         ref_edge = 1'b0;
   logic         ivl_zero = 1'b0;
   logic [N-1:0] clr_en = '0;
   logic         step_o;
   logic [W-1:0] count_o;
   logic         lim_hit_o;
   logic [N-1:0] clr_o;

   always #2.5 clk = ~clk;

   corr_mult_counter #(.CNT_W(W), .N_CLR(N), .RELOAD_VAL(1)) u_corr_mult_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .target_i   (target),
      .limit_i    (limit),
      .ref_edge_i (ref_edge),
      .ivl_zero_i (ivl_zero),
      .clr_en_i   (clr_en),
      .step_o     (step_o),
      .count_o    (count_o),
      .lim_hit_o  (lim_hit_o),
      .clr_o      (clr_o)
   );

   // behavioural reference model
   int       m_cnt = 0;
   bit       m_run = 0;
   bit       m_step = 0;
   bit       m_hit = 0;
   bit [N-1:0] m_clr = '0;

   always @(posedge clk) begin
      int nxt;
      bit stp;
      if (!rst_n) begin
         m_cnt = 0; m_run = 0; m_step = 0; m_hit = 0; m_clr = '0;
      end else begin
         nxt = m_cnt;
         stp = 0;
         if (m_run || (ref_edge && ivl_zero)) begin
            if (m_cnt < int'(limit)) begin
               nxt = m_cnt + 1; stp = 1; m_run = 1;
            end else begin
               nxt = 1; m_run = 0;
            end
         end else if (m_cnt < int'(target) && m_cnt != int'(limit)) begin
            nxt = m_cnt + 1; stp = 1;
         end
         m_hit  = stp && (nxt == int'(limit));
         m_clr  = m_hit ? clr_en : '0;
         m_step = stp;
         m_cnt  = nxt;
      end
   end

   // per-clock comparison
   bit    checking = 0;
   bit    done = 0;
   string cur_req = "R1";
   int    n_chk_cyc = 0;
   int    n_fail_cyc = 0;

   always @(negedge clk) begin
      if (checking && !done) begin
         n_chk_cyc++;
         if (int'(count_o) != m_cnt || step_o !== m_step || lim_hit_o !== m_hit
             || clr_o !== m_clr) begin
            n_fail_cyc++;
            $display("FAIL %s: count=%0d step=%0b hit=%0b clr=%b expected count=%0d step=%0b hit=%0b clr=%b",
                     cur_req, count_o, step_o, lim_hit_o, clr_o, m_cnt, m_step, m_hit, m_clr);
         end
      end
   end

   // watchdog
   int cyc = 0;
   bit wd_fail = 0;
   int n_chk_dir = 0;
   int n_fail_dir = 0;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done && !wd_fail) begin
         wd_fail = 1;
         $display("FAIL watchdog: run did not finish, actual cycles %0d expected below 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk_cyc + n_chk_dir + 1, n_fail_cyc + n_fail_dir + 1);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk_dir++;
      if (!ok) begin
         n_fail_dir++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      tick(3);
      checking = 1;
      chk(count_o == 0 && !step_o && !lim_hit_o && clr_o == '0, "R1", int'(count_o), 0);

      // R2 / R3: track a target below the limit
      rst_n = 1; target = 10; limit = 100; cur_req = "R2";
      tick(1);
      chk(count_o == 1 && step_o, "R2", int'(count_o), 1);
      tick(12);
      cur_req = "R3";
      chk(count_o == 10 && !step_o, "R3", int'(count_o), 10);

      // R5 / R6 / R4: limit below the target
      target = 200; limit = 20; clr_en = 4'b1010; cur_req = "R5";
      tick(10);
      chk(lim_hit_o && count_o == 20, "R5", int'(count_o), 20);
      chk(clr_o == 4'b1010, "R6", int'(clr_o), 10);
      tick(1);
      chk(!lim_hit_o && clr_o == '0, "R5", int'(lim_hit_o), 0);
      cur_req = "R4";
      tick(5);
      chk(count_o == 20 && !step_o, "R4", int'(count_o), 20);

      // R7: reference edge without interval zero
      cur_req = "R7"; ref_edge = 1; ivl_zero = 0;
      tick(1);
      ref_edge = 0;
      tick(1);
      chk(count_o == 20, "R7", int'(count_o), 20);

      // R8: correction at the limit reloads at once
      cur_req = "R8"; ref_edge = 1; ivl_zero = 1;
      tick(1);
      ref_edge = 0; ivl_zero = 0;
      chk(count_o == 1 && !step_o, "R8", int'(count_o), 1);
      cur_req = "R2"; target = 5;
      tick(6);
      chk(count_o == 5, "R2", int'(count_o), 5);

      // R9 / R10: catch-up run ignores a target below the count
      cur_req = "R9"; target = 3; clr_en = 4'b0001; ref_edge = 1; ivl_zero = 1;
      tick(1);
      ref_edge = 0; ivl_zero = 0;
      chk(count_o == 6 && step_o, "R9", int'(count_o), 6);
      cur_req = "R10"; ref_edge = 1; ivl_zero = 1;
      tick(1);
      ref_edge = 0; ivl_zero = 0;
      chk(count_o == 7, "R10", int'(count_o), 7);
      cur_req = "R9";
      tick(13);
      chk(count_o == 20 && lim_hit_o && clr_o == 4'b0001, "R9", int'(count_o), 20);
      tick(1);
      chk(count_o == 1 && !step_o, "R9", int'(count_o), 1);
      cur_req = "R3";
      tick(4);
      chk(count_o == 3 && !step_o, "R3", int'(count_o), 3);

      // R1: reset in the middle of a run abandons it
      cur_req = "R1"; limit = 1000; ref_edge = 1; ivl_zero = 1;
      tick(1);
      ref_edge = 0; ivl_zero = 0;
      tick(3);
      rst_n = 0; target = 0;
      tick(1);
      rst_n = 1;
      tick(5);
      chk(count_o == 0 && !step_o, "R1", int'(count_o), 0);

      // R6: limit match with every clear disabled
      cur_req = "R6"; clr_en = '0; limit = 4; target = 50;
      tick(4);
      chk(lim_hit_o && clr_o == '0 && count_o == 4, "R6", int'(clr_o), 0);
      tick(2);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk_cyc + n_chk_dir, n_fail_cyc + n_fail_dir);
      $finish;
   end
endmodule